// File: doc/BRIEF.md
# MII Management Register Bridge

This block lets a host that only knows byte-wide register reads and writes reach the 16-bit registers of an Ethernet PHY over a two-wire serial management link (management clock plus bidirectional data). The host places the PHY register number in an address register. It then either sets a command bit to fetch that register, or loads a 16-bit value into two write-data bytes. Storing the upper byte is what launches the write.

While a transfer is on the wire, a busy flag is visible both on a pin and in a status register in a separate bank. A fetched value appears in two read-data bytes, and both bytes change in the same clock cycle. The host interface is plain register access with no handshake: a write takes effect on the clock edge where `reg_wr` is high, and `reg_rdata` follows the bank and offset selection combinationally. The serial pins are plain as well.

Top module: `mdio_reg_bridge`

## Requirements
- R1: After reset every host register reads 0x00, `busy`, `mdc` and `mdio_oe` are low.
- R2: Bank 2 holds the PHY register number at offset 0x14 (5 bits), the command byte at 0x12, write data at 0x16 (low) and 0x17 (high), and read data at 0x18 (low) and 0x19 (high). Bank 3 offset 0x0A is status: bit 0 busy, bit 1 scan (always 0), bit 2 not-valid (always 0). Writable registers read back what was written.
- R3: Writing the command byte with bit 0 = 1 while idle starts a PHY register read. The bit stays set until the host clears it.
- R4: Writing offset 0x17 while idle starts a PHY write of {byte at 0x17, byte at 0x16}.
- R5: `busy` is high from the cycle after the triggering write for exactly DIV*(PRE_LEN+32) clock cycles (256 with the defaults).
- R6: The serial frame is PRE_LEN ones, start 01, opcode (10 read, 01 write), PHY address (parameter, default 1), register number, turnaround, then 16 data bits. Fields are sent most significant bit first. A write drives turnaround 10. A read releases the data line (`mdio_oe` low) from the turnaround to the end of the frame.
- R7: `mdc` has period DIV clock cycles and is low for the first DIV/2 cycles of each bit. `mdio_o` changes only when a bit period starts, and `mdio_i` is sampled while `mdc` is high.
- R8: Both read-data bytes update together in the cycle `busy` falls after a read, and hold their value while `busy` is high.
- R9: Every host register write that arrives while `busy` is high is dropped, including triggers.
- R10: Reading PHY registers 2 and 3 returns the identifier 0x0083, and 0x1400 under mask 0xFC00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host write strobe |
| reg_bank | input | 2 | Host bank select |
| reg_addr | input | 5 | Host register offset |
| reg_wdata | input | 8 | Host write byte |
| reg_rdata | output | 8 | Selected register contents |
| busy | output | 1 | Transfer in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The triggering write is captured on one clock edge. `busy` is then sampled on every following falling clock edge, and exactly 256 high samples are expected before it drops. The read-data bytes are compared at the falling edge after `busy` drops, and again in the middle of a transfer, where they must still hold their old value. The PHY model acts on falling-clock samples of `mdc`. It reads the data line half a bit after the line changes, and it drives read data when `mdc` falls. That gives the design DIV/2 cycles of setup time, and the model counts any deviation from the frame layout for the bench to check after each transfer.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
  localparam logic [1:0] BANK_MII  = 2'd2;
  localparam logic [1:0] BANK_STAT = 2'd3;
  localparam logic [4:0] OFS_CMD   = 5'h12;
  localparam logic [4:0] OFS_PREG  = 5'h14;
  localparam logic [4:0] OFS_WLO   = 5'h16;
  localparam logic [4:0] OFS_WHI   = 5'h17;
  localparam logic [4:0] OFS_RLO   = 5'h18;
  localparam logic [4:0] OFS_RHI   = 5'h19;
  localparam logic [4:0] OFS_STAT  = 5'h0A;

  typedef enum logic [1:0] {
    OPC_WRITE = 2'b01,
    OPC_READ  = 2'b10
  } mgmt_op_e;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic bit_end,
  output logic sample_now
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;
  localparam logic [CW-1:0] LAST_C = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF_C = CW'(HALF);

  logic [CW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               phase <= '0;
    else if (!run)            phase <= '0;
    else if (phase == LAST_C) phase <= '0;
    else                      phase <= phase + 1'b1;
  end

  assign mdc        = run && (phase >= HALF_C);
  assign bit_end    = run && (phase == LAST_C);
  assign sample_now = run && (phase == HALF_C);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_bridge_pkg::*;
#(
  parameter int         PRE_LEN  = 32,
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_rd,
  input  logic        start_wr,
  input  logic [4:0]  reg_sel,
  input  logic [15:0] tx_word,
  input  logic        bit_end,
  input  logic        sample_now,
  input  logic        mdio_i,
  output logic        active,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        rd_done,
  output logic [15:0] rd_word
);
  localparam int TOTAL = PRE_LEN + 32;
  localparam int BW    = $clog2(TOTAL);
  localparam logic [BW-1:0] LAST_B = BW'(TOTAL - 1);
  localparam logic [BW-1:0] TA_B   = BW'(PRE_LEN + 14);
  localparam logic [BW-1:0] DAT_B  = BW'(PRE_LEN + 16);
  localparam logic [PRE_LEN-1:0] PRE_ONES = '1;

  logic [TOTAL-1:0] shreg;
  logic [BW-1:0]    bitno;
  logic             is_read;
  logic [15:0]      rx;
  logic [TOTAL-1:0] frame;
  mgmt_op_e         opc;

  always_comb begin
    opc   = start_rd ? OPC_READ : OPC_WRITE;
    frame = start_rd ? {PRE_ONES, 2'b01, opc, PHY_ADDR, reg_sel, 2'b11, 16'hFFFF}
                     : {PRE_ONES, 2'b01, opc, PHY_ADDR, reg_sel, 2'b10, tx_word};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      bitno   <= '0;
      shreg   <= '0;
      is_read <= 1'b0;
      rx      <= '0;
    end else if (!active) begin
      if (start_rd || start_wr) begin
        active  <= 1'b1;
        bitno   <= '0;
        shreg   <= frame;
        is_read <= start_rd;
      end
    end else begin
      if (sample_now && is_read && (bitno >= DAT_B))
        rx <= {rx[14:0], mdio_i};
      if (bit_end) begin
        shreg <= shreg << 1;
        if (bitno == LAST_B) active <= 1'b0;
        else                 bitno  <= bitno + 1'b1;
      end
    end
  end

  assign mdio_o  = shreg[TOTAL-1];
  assign mdio_oe = active && !(is_read && (bitno >= TA_B));
  assign rd_done = active && is_read && bit_end && (bitno == LAST_B);
  assign rd_word = rx;

  assert_frame_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(bitno) == LAST_B));
  assert_bit_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(bit_end)) |-> $stable(mdio_o));
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !mdio_oe) |=> (!mdio_oe || !active));
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_bank,
  input  logic [4:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  input  logic        busy,
  input  logic        rd_done,
  input  logic [15:0] rd_word,
  output logic [7:0]  reg_rdata,
  output logic        start_rd,
  output logic        start_wr,
  output logic [4:0]  reg_sel,
  output logic [15:0] tx_word
);
  logic [4:0]  preg_q;
  logic [7:0]  cmd_q, wlo_q, whi_q;
  logic [15:0] rd_q;
  logic        take, in_mii;

  assign take     = reg_wr && !busy;
  assign in_mii   = (reg_bank == BANK_MII);
  assign start_rd = take && in_mii && (reg_addr == OFS_CMD) && reg_wdata[0];
  assign start_wr = take && in_mii && (reg_addr == OFS_WHI);
  assign reg_sel  = preg_q;
  assign tx_word  = {reg_wdata, wlo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preg_q <= '0;
      cmd_q  <= '0;
      wlo_q  <= '0;
      whi_q  <= '0;
      rd_q   <= '0;
    end else begin
      if (take && in_mii) begin
        case (reg_addr)
          OFS_PREG: preg_q <= reg_wdata[4:0];
          OFS_CMD:  cmd_q  <= reg_wdata;
          OFS_WLO:  wlo_q  <= reg_wdata;
          OFS_WHI:  whi_q  <= reg_wdata;
          default:  ;
        endcase
      end
      if (rd_done) rd_q <= rd_word;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (in_mii) begin
      case (reg_addr)
        OFS_PREG: reg_rdata = {3'b000, preg_q};
        OFS_CMD:  reg_rdata = cmd_q;
        OFS_WLO:  reg_rdata = wlo_q;
        OFS_WHI:  reg_rdata = whi_q;
        OFS_RLO:  reg_rdata = rd_q[7:0];
        OFS_RHI:  reg_rdata = rd_q[15:8];
        default:  reg_rdata = 8'h00;
      endcase
    end else if (reg_bank == BANK_STAT && reg_addr == OFS_STAT) begin
      reg_rdata = {5'b00000, 1'b0, 1'b0, busy};
    end
  end

  assert_trigger_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rd || start_wr) |=> busy);
  assert_drop_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && busy) |=> ($stable(preg_q) && $stable(cmd_q) && $stable(wlo_q) && $stable(whi_q)));
  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rd_q));
endmodule

// File: rtl/mdio_reg_bridge.sv
module mdio_reg_bridge #(
  parameter int         DIV      = 4,
  parameter int         PRE_LEN  = 32,
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_bank,
  input  logic [4:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       busy,
  output logic       mdc,
  output logic       mdio_o,
  output logic       mdio_oe,
  input  logic       mdio_i
);
  logic        start_rd, start_wr, bit_end, sample_now, rd_done;
  logic [4:0]  reg_sel;
  logic [15:0] tx_word, rd_word;

  mdio_host_regs u_regs (
    .clk, .rst_n, .reg_wr, .reg_bank, .reg_addr, .reg_wdata,
    .busy, .rd_done, .rd_word, .reg_rdata,
    .start_rd, .start_wr, .reg_sel, .tx_word
  );

  mdio_clk_div #(.DIV(DIV)) u_div (
    .clk, .rst_n, .run(busy), .mdc, .bit_end, .sample_now
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN), .PHY_ADDR(PHY_ADDR)) u_eng (
    .clk, .rst_n, .start_rd, .start_wr, .reg_sel, .tx_word,
    .bit_end, .sample_now, .mdio_i,
    .active(busy), .mdio_o, .mdio_oe, .rd_done, .rd_word
  );
endmodule

// File: tb/mdio_reg_bridge_test.sv
module mdio_reg_bridge_test;
  localparam int DIV = 4;
  localparam int PRE = 32;
  localparam int TOT = PRE + 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_bank = 2'd0;
  logic [4:0] reg_addr = 5'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic busy, mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  mdio_reg_bridge #(.DIV(DIV), .PRE_LEN(PRE), .PHY_ADDR(5'd1)) uut (
    .clk, .rst_n, .reg_wr, .reg_bank, .reg_addr, .reg_wdata, .reg_rdata,
    .busy, .mdc, .mdio_o, .mdio_oe, .mdio_i
  );

  // PHY model: register array plus frame checker
  logic [15:0] phy_mem [32];
  int   bitcnt = 0, frame_err = 0;
  logic mdc_q = 1'b0;
  logic [1:0] m_op;
  logic [4:0] m_reg;
  logic [15:0] m_wsh;

  initial begin
    for (int i = 0; i < 32; i++) phy_mem[i] = 16'h0000;
    phy_mem[2] = 16'h0083;
    phy_mem[3] = 16'h1405;
  end

  always @(negedge clk) begin
    if (!busy) bitcnt = 0;
    else if (mdc && !mdc_q) begin
      if (bitcnt < PRE) begin
        if (mdio_o !== 1'b1 || !mdio_oe) frame_err++;
      end else if (bitcnt == PRE)   begin if (mdio_o !== 1'b0) frame_err++; end
      else if (bitcnt == PRE+1)     begin if (mdio_o !== 1'b1) frame_err++; end
      else if (bitcnt <= PRE+3)     m_op = {m_op[0], mdio_o};
      else if (bitcnt <= PRE+8)     begin if (mdio_o !== (bitcnt == PRE+8)) frame_err++; end
      else if (bitcnt <= PRE+13)    m_reg = {m_reg[3:0], mdio_o};
      else if (m_op == 2'b10)       begin if (mdio_oe) frame_err++; end
      else begin
        if (!mdio_oe) frame_err++;
        if (bitcnt == PRE+14 && mdio_o !== 1'b1) frame_err++;
        if (bitcnt == PRE+15 && mdio_o !== 1'b0) frame_err++;
        if (bitcnt >= PRE+16) m_wsh = {m_wsh[14:0], mdio_o};
        if (bitcnt == TOT-1) phy_mem[m_reg] = m_wsh;
      end
      if (bitcnt < PRE+14 && !mdio_oe) frame_err++;
      bitcnt++;
    end else if (!mdc && mdc_q) begin
      if (m_op == 2'b10 && bitcnt >= PRE+16)
        mdio_i = phy_mem[m_reg][TOT-1-bitcnt];
      else
        mdio_i = 1'b1;
    end
    mdc_q = mdc;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] b, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_bank = b; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] b, input logic [4:0] a, output logic [7:0] d);
    reg_bank = b; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
  endtask

  task automatic txn(input bit wr, input logic [4:0] r, input logic [15:0] d);
    host_wr(2'd2, 5'h14, {3'b000, r});
    if (wr) begin
      host_wr(2'd2, 5'h16, d[7:0]);
      host_wr(2'd2, 5'h17, d[15:8]);
    end else begin
      host_wr(2'd2, 5'h12, 8'h01);
    end
    wait_idle();
    if (!wr) host_wr(2'd2, 5'h12, 8'h00);
  endtask

  // vector: {write, reg, data, expected, mask}
  localparam int NV = 7;
  localparam logic [53:0] VEC [NV] = '{
    {1'b0, 5'd2,  16'h0000, 16'h0083, 16'hFFFF},
    {1'b0, 5'd3,  16'h0000, 16'h1400, 16'hFC00},
    {1'b1, 5'd5,  16'hA5C3, 16'h0000, 16'h0000},
    {1'b0, 5'd5,  16'h0000, 16'hA5C3, 16'hFFFF},
    {1'b1, 5'd31, 16'h8001, 16'h0000, 16'h0000},
    {1'b0, 5'd31, 16'h0000, 16'h8001, 16'hFFFF},
    {1'b0, 5'd0,  16'h0000, 16'h0000, 16'hFFFF}
  };

  initial begin
    #(200000 * 20);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] lo, hi, b8;
    logic [15:0] got;
    int ferr0, cnt, r1, r2, hcnt;

    repeat (3) @(negedge clk);
    // R1 reset state
    host_rd(2'd2, 5'h14, b8); check(b8 == 0, "R1 preg", b8, 0);
    host_rd(2'd2, 5'h18, b8); check(b8 == 0, "R1 rdlo", b8, 0);
    check(!busy && !mdc && !mdio_oe, "R1 pins", {busy, mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    host_rd(2'd3, 5'h0A, b8); check(b8 == 0, "R1 status", b8, 0);

    // R2 readback
    host_wr(2'd2, 5'h14, 8'h0A);
    host_rd(2'd2, 5'h14, b8); check(b8 == 8'h0A, "R2 preg", b8, 8'h0A);
    host_wr(2'd2, 5'h16, 8'h3C);
    host_rd(2'd2, 5'h16, b8); check(b8 == 8'h3C, "R2 wlo", b8, 8'h3C);

    // R3 R4 R6 R10 table walk
    for (int v = 0; v < NV; v++) begin
      ferr0 = frame_err;
      txn(VEC[v][53], VEC[v][52:48], VEC[v][47:32]);
      check(frame_err == ferr0, "R6 frame", frame_err, ferr0);
      if (!VEC[v][53]) begin
        host_rd(2'd2, 5'h18, lo);
        host_rd(2'd2, 5'h19, hi);
        got = {hi, lo};
        check((got & VEC[v][15:0]) == VEC[v][31:16], "R3 R10 read data",
              got & VEC[v][15:0], VEC[v][31:16]);
      end
    end
    host_rd(2'd2, 5'h12, b8); check(b8 == 8'h00, "R3 cmd cleared", b8, 0);

    // R5 busy length, R7 mdc, R8 hold, R9 drop, R2 status busy
    host_wr(2'd2, 5'h14, 8'h02);
    host_wr(2'd2, 5'h12, 8'h01);
    check(busy == 1'b1, "R5 busy rise", busy, 1);
    host_rd(2'd3, 5'h0A, b8); check(b8 == 8'h01, "R2 status busy", b8, 1);
    host_rd(2'd2, 5'h12, b8); check(b8 == 8'h01, "R3 cmd held", b8, 1);
    cnt = 0; r1 = -1; r2 = -1; hcnt = 0;
    while (busy && cnt < 1000) begin
      if (cnt > 0 && mdc && !mdc_q) begin
        if (r1 < 0) r1 = cnt; else if (r2 < 0) r2 = cnt;
      end
      if (mdc && r1 >= 0 && r2 < 0) hcnt++;
      if (cnt == 100) begin
        host_rd(2'd2, 5'h18, lo);
        check(lo == 8'h00, "R8 hold while busy", lo, 8'h00);
        reg_wr = 1'b1; reg_bank = 2'd2; reg_addr = 5'h17; reg_wdata = 8'h77;
      end else if (cnt == 101) begin
        reg_addr = 5'h14; reg_wdata = 8'h09;
      end else begin
        reg_wr = 1'b0;
      end
      cnt++;
      @(negedge clk);
    end
    check(cnt == DIV * TOT, "R5 busy length", cnt, DIV * TOT);
    check(r2 - r1 == DIV, "R7 mdc period", r2 - r1, DIV);
    check(hcnt == DIV / 2, "R7 mdc high", hcnt, DIV / 2);
    host_rd(2'd2, 5'h18, lo);
    host_rd(2'd2, 5'h19, hi);
    check({hi, lo} == 16'h0083, "R8 R10 update at fall", {hi, lo}, 16'h0083);
    host_rd(2'd2, 5'h14, b8); check(b8 == 8'h02, "R9 preg kept", b8, 8'h02);
    host_rd(2'd2, 5'h17, b8); check(b8 == 8'h80, "R9 whi kept", b8, 8'h80);
    @(negedge clk);
    check(!busy, "R9 no relaunch", busy, 0);
    host_wr(2'd2, 5'h12, 8'h00);
    txn(1'b0, 5'd31, 16'h0);
    host_rd(2'd2, 5'h18, lo);
    host_rd(2'd2, 5'h19, hi);
    check({hi, lo} == 16'h8001, "R9 phy untouched", {hi, lo}, 16'h8001);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule